// File: doc/BRIEF.md
# Trigger-Matched Hit Buffer and Packet Builder

This block sits between the front-end readout chips of a strip tracker and the downstream event collector. The front end sends only channels above threshold, so hit words come as a sparse stream with a variable and often zero number of words per beam crossing. Each word carries its own 8-bit crossing tag. The block keeps every incoming word in a circular store. Entries are released once they are older than a rolling window of 64 beam crossings, so the store covers that window and nothing older.

A local crossing counter advances on every beam-clock strobe. When a Level-1 accept pulse arrives, the block takes the current crossing count minus a programmable latency, modulo 256, as the triggered crossing. It scans the store twice. The first pass counts the words whose tag equals the triggered crossing. The second pass emits a header followed by those words in arrival order, as one framed packet on a valid/ready output. Accepts that arrive while a packet is still being built wait in a small queue and are served in order. Words that arrive when the store is full are dropped and counted, and the next header reports the loss.

Top module: `l1_hit_matcher`

## Requirements
- R1: A crossing counter, 0 after reset, increments by one (mod 256) on each cycle with `bx_strobe` high. On an `l1_accept` cycle the triggered crossing is that count minus `l1_latency`, mod 256. The header carries it in bits [7:0].
- R2: A hit word carries its crossing tag in bits [7:0]. The packet holds, unchanged and in arrival order, exactly the stored words whose tag equals the triggered crossing.
- R3: Every packet starts with one header word that has `pkt_sop` high. Header bit 23 is the overflow flag, bit 22 the latency-reject flag, bits [21:14] the number of hit words that follow, and bits [13:8] are zero. `pkt_eop` is high on the last word only.
- R4: When no stored word matches, the packet is the header alone, with `pkt_sop` and `pkt_eop` both high and a count of 0.
- R5: An accept with `l1_latency` above 63 sets the reject flag and yields an empty packet. A latency of exactly 63 is accepted.
- R6: A word offered when the store holds `HIT_DEPTH` entries is dropped and `ovf_count` increments (saturating). The next packet header has the overflow flag set, and the flag is clear in the packet after that.
- R7: A word whose age, in crossings since it was stored, reaches 64 is freed. It is never selected again, even when its tag aliases the triggered crossing after the 8-bit count wraps, and its space is reused.
- R8: Accepts that arrive while a packet is in progress are queued (up to `TRIG_DEPTH`, default 4) and produce their packets in arrival order.
- R9: `hit_ready` is low while a packet is in progress. A packet word held with `pkt_ready` low stays unchanged until it is taken.
- R10: After reset `pkt_valid` is low, `hit_ready` is high and `ovf_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | Hit word offered |
| hit_data | input | 24 | Hit word: channel [23:15], amplitude [14:12], chip [11:8], crossing tag [7:0] |
| hit_ready | output | 1 | Hit word can be taken |
| bx_strobe | input | 1 | One-cycle beam-crossing strobe |
| l1_accept | input | 1 | One-cycle Level-1 accept |
| l1_latency | input | 8 | Crossings between the triggered crossing and the accept |
| pkt_valid | output | 1 | Packet word available |
| pkt_ready | input | 1 | Downstream takes the packet word |
| pkt_data | output | 24 | Header or hit word |
| pkt_sop | output | 1 | First word of a packet |
| pkt_eop | output | 1 | Last word of a packet |
| ovf_count | output | OVF_W | Saturating count of dropped hit words |

## Verification
A wrong store pointer or occupancy shows up in the next packet. Words go missing, repeat or come out of order, or the header count differs from the number of words that follow, so the fault is caught at the first accept after the fault. A stale-expiry fault appears only after the window or the 8-bit count has wrapped. For that reason the bench advances 256 crossings and triggers on an aliased tag. A lost or stuck overflow flag shows in the header bit of the next two packets. A trigger-queue fault shows as packets in the wrong order or as a missing packet right after a burst of accepts.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int WORD_W  = 24;
  localparam int BX_W    = 8;
  localparam int TAG_LSB = 0;
  localparam int HDR_OVF = 23;
  localparam int HDR_REJ = 22;
  localparam int HDR_CNT = 14;
  localparam int CNT_W   = 8;

  typedef enum logic [1:0] {
    PK_IDLE,
    PK_COUNT,
    PK_HEAD,
    PK_EMIT
  } pk_state_t;
endpackage

// File: rtl/hm_store.sv
module hm_store
  import hm_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int WINDOW = 64,
  parameter int OVF_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int OW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BX_W-1:0]   bx_now,
  input  logic              expire_en,
  input  logic [AW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [AW-1:0]     head_ptr,
  output logic [OW-1:0]     occ,
  output logic              drop,
  output logic [OVF_W-1:0]  drop_cnt
);
  logic [WORD_W-1:0] mem_word [DEPTH];
  logic [BX_W-1:0]   mem_bx   [DEPTH];
  logic [AW-1:0]     wr_ptr, wr_ptr_n, head_n;
  logic [OW-1:0]     occ_n;
  logic [OVF_W-1:0]  drop_cnt_n;
  logic [BX_W-1:0]   head_age;
  logic              full, wr_ok, expire;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (occ == OW'(DEPTH));
  assign wr_ok    = wr_req && !full;
  assign drop     = wr_req && full;
  assign head_age = bx_now - mem_bx[head_ptr];
  assign expire   = expire_en && (occ != '0) && (head_age >= BX_W'(WINDOW));
  assign rd_word  = mem_word[rd_idx];

  always_comb begin
    wr_ptr_n   = wr_ptr;
    head_n     = head_ptr;
    occ_n      = occ;
    drop_cnt_n = drop_cnt;
    if (wr_ok) wr_ptr_n = step(wr_ptr);
    if (expire) head_n = step(head_ptr);
    case ({wr_ok, expire})
      2'b10:   occ_n = occ + 1'b1;
      2'b01:   occ_n = occ - 1'b1;
      default: occ_n = occ;
    endcase
    if (drop && !(&drop_cnt)) drop_cnt_n = drop_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      head_ptr <= '0;
      occ      <= '0;
      drop_cnt <= '0;
    end else begin
      wr_ptr   <= wr_ptr_n;
      head_ptr <= head_n;
      occ      <= occ_n;
      drop_cnt <= drop_cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_word[wr_ptr] <= wr_data;
      mem_bx[wr_ptr]   <= bx_now;
    end
  end

  p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full) |=> $stable(wr_ptr));
endmodule

// File: rtl/hm_trig_fifo.sv
module hm_trig_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty
);
  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push   = push && (cnt != CW'(DEPTH));
  assign do_pop    = pop && (cnt != '0);
  assign not_empty = (cnt != '0);
  assign dout      = slot[rp];

  always_comb begin
    wp_n  = do_push ? step(wp) : wp;
    rp_n  = do_pop ? step(rp) : rp;
    cnt_n = cnt;
    if (do_push && !do_pop) cnt_n = cnt + 1'b1;
    else if (!do_push && do_pop) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot[wp] <= din;
  end

  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/hm_packer.sv
module hm_packer
  import hm_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [BX_W-1:0]   trig_bx,
  input  logic              trig_err,
  output logic              trig_pop,
  input  logic [AW-1:0]     head_ptr,
  input  logic [OW-1:0]     occ,
  output logic [AW-1:0]     rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              ovf_event,
  output logic              idle,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [WORD_W-1:0] pkt_data,
  output logic              pkt_sop,
  output logic              pkt_eop
);
  pk_state_t       st, st_n;
  logic [BX_W-1:0] tgt_q, tgt_n;
  logic            err_q, err_n;
  logic [AW-1:0]   idx_q, idx_n, base_q, base_n;
  logic [OW-1:0]   left_q, left_n, snap_q, snap_n;
  logic [OW-1:0]   total_q, total_n, sent_q, sent_n;
  logic            ovf_q, ovf_n;
  logic            match, hdr_fire, last_hit;
  logic [WORD_W-1:0] header;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign match    = !err_q && (rd_word[TAG_LSB +: BX_W] == tgt_q);
  assign last_hit = ((sent_q + 1'b1) == total_q);
  assign rd_idx   = idx_q;
  assign idle     = (st == PK_IDLE);
  assign header   = {ovf_q, err_q, CNT_W'(total_q), 6'b0, tgt_q};
  assign hdr_fire = (st == PK_HEAD) && pkt_ready;

  always_comb begin
    st_n      = st;
    tgt_n     = tgt_q;
    err_n     = err_q;
    idx_n     = idx_q;
    base_n    = base_q;
    left_n    = left_q;
    snap_n    = snap_q;
    total_n   = total_q;
    sent_n    = sent_q;
    trig_pop  = 1'b0;
    pkt_valid = 1'b0;
    pkt_sop   = 1'b0;
    pkt_eop   = 1'b0;
    pkt_data  = rd_word;
    case (st)
      PK_IDLE: begin
        if (trig_valid) begin
          trig_pop = 1'b1;
          st_n     = PK_COUNT;
          tgt_n    = trig_bx;
          err_n    = trig_err;
          idx_n    = head_ptr;
          base_n   = head_ptr;
          left_n   = occ;
          snap_n   = occ;
          total_n  = '0;
        end
      end
      PK_COUNT: begin
        if (left_q == '0) begin
          st_n = PK_HEAD;
        end else begin
          if (match) total_n = total_q + 1'b1;
          idx_n  = step(idx_q);
          left_n = left_q - 1'b1;
        end
      end
      PK_HEAD: begin
        pkt_valid = 1'b1;
        pkt_sop   = 1'b1;
        pkt_eop   = (total_q == '0);
        pkt_data  = header;
        if (pkt_ready) begin
          st_n   = (total_q == '0) ? PK_IDLE : PK_EMIT;
          idx_n  = base_q;
          left_n = snap_q;
          sent_n = '0;
        end
      end
      PK_EMIT: begin
        if (left_q == '0) begin
          st_n = PK_IDLE;
        end else if (match) begin
          pkt_valid = 1'b1;
          pkt_eop   = last_hit;
          if (pkt_ready) begin
            idx_n  = step(idx_q);
            left_n = left_q - 1'b1;
            sent_n = sent_q + 1'b1;
            if (last_hit) st_n = PK_IDLE;
          end
        end else begin
          idx_n  = step(idx_q);
          left_n = left_q - 1'b1;
        end
      end
      default: st_n = PK_IDLE;
    endcase
    if (ovf_event) ovf_n = 1'b1;
    else if (hdr_fire) ovf_n = 1'b0;
    else ovf_n = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PK_IDLE;
      tgt_q   <= '0;
      err_q   <= 1'b0;
      idx_q   <= '0;
      base_q  <= '0;
      left_q  <= '0;
      snap_q  <= '0;
      total_q <= '0;
      sent_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      st      <= st_n;
      tgt_q   <= tgt_n;
      err_q   <= err_n;
      idx_q   <= idx_n;
      base_q  <= base_n;
      left_q  <= left_n;
      snap_q  <= snap_n;
      total_q <= total_n;
      sent_q  <= sent_n;
      ovf_q   <= ovf_n;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=>
      (pkt_valid && $stable(pkt_data) && $stable(pkt_sop) && $stable(pkt_eop)));
  p_reject_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_sop && pkt_data[HDR_REJ]) |->
      (pkt_eop && (pkt_data[HDR_CNT +: CNT_W] == '0)));
  p_hdr_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_sop) |-> (pkt_data[13:8] == 6'b0));
endmodule

// File: rtl/l1_hit_matcher.sv
module l1_hit_matcher
  import hm_pkg::*;
#(
  parameter int HIT_DEPTH  = 32,
  parameter int WINDOW     = 64,
  parameter int TRIG_DEPTH = 4,
  parameter int OVF_W      = 16,
  localparam int AW        = $clog2(HIT_DEPTH),
  localparam int OW        = $clog2(HIT_DEPTH + 1),
  localparam int TW        = BX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [23:0]       hit_data,
  output logic              hit_ready,
  input  logic              bx_strobe,
  input  logic              l1_accept,
  input  logic [7:0]        l1_latency,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [23:0]       pkt_data,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic [OVF_W-1:0]  ovf_count
);
  logic [BX_W-1:0]   bx_cnt, bx_cnt_n;
  logic [TW-1:0]     trig_in, trig_out;
  logic              trig_valid, trig_pop;
  logic [AW-1:0]     rd_idx, head_ptr;
  logic [OW-1:0]     occ;
  logic [WORD_W-1:0] rd_word;
  logic              drop, idle;

  always_comb begin
    bx_cnt_n = bx_strobe ? bx_cnt + 1'b1 : bx_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bx_cnt <= '0;
    else        bx_cnt <= bx_cnt_n;
  end

  assign trig_in   = {(l1_latency > 8'(WINDOW - 1)), bx_cnt - l1_latency};
  assign hit_ready = idle;

  hm_trig_fifo #(.DEPTH(TRIG_DEPTH), .W(TW)) u_tq (
    .clk(clk), .rst_n(rst_n), .push(l1_accept), .din(trig_in),
    .pop(trig_pop), .dout(trig_out), .not_empty(trig_valid)
  );

  hm_store #(.DEPTH(HIT_DEPTH), .WINDOW(WINDOW), .OVF_W(OVF_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(hit_valid && hit_ready),
    .wr_data(hit_data), .bx_now(bx_cnt), .expire_en(idle),
    .rd_idx(rd_idx), .rd_word(rd_word), .head_ptr(head_ptr), .occ(occ),
    .drop(drop), .drop_cnt(ovf_count)
  );

  hm_packer #(.DEPTH(HIT_DEPTH)) u_pack (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid),
    .trig_bx(trig_out[BX_W-1:0]), .trig_err(trig_out[BX_W]),
    .trig_pop(trig_pop), .head_ptr(head_ptr), .occ(occ), .rd_idx(rd_idx),
    .rd_word(rd_word), .ovf_event(drop), .idle(idle),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop)
  );

  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !hit_ready);
  p_bx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_strobe |=> $stable(bx_cnt));
endmodule

// File: tb/l1_hit_matcher_test.sv
module l1_hit_matcher_test;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n, hit_valid, hit_ready, bx_strobe, l1_accept;
  logic [7:0]  l1_latency;
  logic        pkt_valid, pkt_ready, pkt_sop, pkt_eop;
  logic [23:0] hit_data, pkt_data;
  logic [15:0] ovf_count;

  always #10 clk = ~clk;

  l1_hit_matcher uut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_data(hit_data),
    .hit_ready(hit_ready), .bx_strobe(bx_strobe), .l1_accept(l1_accept),
    .l1_latency(l1_latency), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .ovf_count(ovf_count)
  );

  int          checks = 0, errors = 0, busy_bad = 0, ovf_model = 0;
  logic [25:0] expq[$];
  string       expr[$];
  logic [23:0] mw[$];
  logic [7:0]  mb[$];
  logic [7:0]  bx = 8'd0;
  bit          ovfm = 1'b0, bp = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_hit(input logic [7:0] tag, input int ch);
    logic [23:0] w;
    w = {9'(ch + 17), 3'(ch), 4'(ch >> 2), tag};
    @(negedge clk);
    hit_valid = 1'b1;
    hit_data  = w;
    while (!hit_ready) @(negedge clk);
    @(negedge clk);
    hit_valid = 1'b0;
    if (mw.size() < DEPTH) begin
      mw.push_back(w);
      mb.push_back(bx);
    end else begin
      ovfm = 1'b1;
      ovf_model++;
    end
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      int k;
      @(negedge clk);
      bx_strobe = 1'b1;
      @(negedge clk);
      bx_strobe = 1'b0;
      bx = bx + 8'd1;
      k = 0;
      while (mw.size() > 0 && 8'(bx - mb[0]) >= 8'd64) begin
        void'(mw.pop_front());
        void'(mb.pop_front());
        k++;
      end
      tick(k + 2);
    end
  endtask

  task automatic trigger(input int lat, input string req);
    logic [7:0]  tgt;
    bit          rej;
    int          n, m;
    logic [23:0] hdr;
    tgt = bx - 8'(lat);
    rej = (lat > 63);
    n = 0;
    if (!rej) foreach (mw[i]) if (mw[i][7:0] == tgt) n++;
    hdr = {ovfm, rej, 8'(n), 6'b0, tgt};
    ovfm = 1'b0;
    expq.push_back({1'b1, (n == 0), hdr});
    expr.push_back(req);
    m = 0;
    if (!rej) foreach (mw[i]) if (mw[i][7:0] == tgt) begin
      m++;
      expq.push_back({1'b0, (m == n), mw[i]});
      expr.push_back(req);
    end
    @(negedge clk);
    l1_accept  = 1'b1;
    l1_latency = 8'(lat);
    @(negedge clk);
    l1_accept = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    tick(4);
  endtask

  initial begin
    pkt_ready = 1'b1;
    forever begin
      @(negedge clk);
      pkt_ready = bp ? ~pkt_ready : 1'b1;
    end
  end

  initial begin
    logic [25:0] e;
    string       r;
    forever begin
      @(negedge clk);
      #1;
      if (pkt_valid && hit_ready) busy_bad++;
      if (pkt_valid && pkt_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected word", {pkt_sop, pkt_eop, pkt_data}, 0);
        end else begin
          e = expq.pop_front();
          r = expr.pop_front();
          chk({pkt_sop, pkt_eop, pkt_data} === e, r, "packet word",
              {pkt_sop, pkt_eop, pkt_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hit_valid = 1'b0; hit_data = '0; bx_strobe = 1'b0;
    l1_accept = 1'b0; l1_latency = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(pkt_valid == 1'b0, "R10", "pkt_valid after reset", pkt_valid, 0);
    chk(hit_ready == 1'b1, "R10", "hit_ready after reset", hit_ready, 1);
    chk(ovf_count == 16'd0, "R10", "ovf_count after reset", ovf_count, 0);

    // R1 R2 R3: crossing arithmetic, tag selection, ordering, framing
    strobe(5);
    send_hit(8'd3, 1); send_hit(8'd5, 2); send_hit(8'd3, 3); send_hit(8'd4, 4);
    trigger(2, "R2");
    drain();
    // R9: backpressure on the packet output
    bp = 1'b1;
    trigger(0, "R9");
    trigger(1, "R1");
    drain();
    bp = 1'b0;
    // R4: no matching word
    trigger(5, "R4");
    drain();
    // R5: latency above 63 rejected
    trigger(64, "R5");
    drain();
    // R5 R7 boundary: age 63 still stored, latency 63 accepted
    strobe(63);
    trigger(63, "R5");
    drain();
    strobe(1);
    // R8: queued accepts
    send_hit(8'd69, 5); send_hit(8'd68, 6); send_hit(8'd69, 7); send_hit(8'd67, 8);
    trigger(0, "R8");
    trigger(1, "R8");
    trigger(2, "R8");
    drain();
    // R7: full wrap of the count, aliased tag must not match
    strobe(256);
    trigger(0, "R7");
    drain();
    // R6: overflow and flag in the next header only
    for (int i = 0; i < DEPTH + 2; i++) send_hit(bx, i);
    tick(2);
    chk(ovf_count == 16'(ovf_model), "R6", "ovf_count after fill", ovf_count, ovf_model);
    trigger(0, "R6");
    drain();
    trigger(0, "R6");
    drain();
    chk(busy_bad == 0, "R9", "hit_ready high during packet", busy_bad, 0);
    chk(expq.size() == 0, "R8", "packets outstanding", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule